// File: doc/BRIEF.md
# Stairstep-Ramp Conversion Controller

This block is the digital half of a counter-type analog-to-digital converter. An up-counter that starts at zero drives the code input of an external DAC. One comparator bit reports whether the DAC output now lies above the analog input. When it does, the controller stores the code that caused the trip in a result register and pulses a valid strobe for one clock. It then starts a new ramp from zero. The comparator is asynchronous to the clock, so it is passed through a synchronizer. Each comparator answer is tracked against the code that produced it, which means the synchronizer delay does not bias the result.

Each conversion starts from zero, so a low input finishes quickly and a high input takes close to the full count. The result register holds the last value steady while the next ramp runs. If the ramp reaches the all-ones code and the comparator never trips, the all-ones code is reported as a full-scale result.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: Outside reset, and except on a restart or a hold at full scale, `dac_code_o` rises by exactly one each clock.
- R2: The result is the first code whose comparator answer was high. With a comparator that is high when code > level, for a constant level L the result is min(L+1, 2^CODE_W-1).
- R3: `result_o` changes only in a cycle where `result_valid_o` is high. It stays stable in every other cycle.
- R4: For a constant input, consecutive valid pulses are exactly result + SYNC_STAGES + 1 clocks apart (with the defaults, result + 3). Low levels therefore update more often than high ones.
- R5: When `dac_code_o` reaches all ones, it holds there until the comparator answer for that code arrives. If that answer is low, all ones is captured as the result.
- R6: `cmp_above_i` passes through a SYNC_STAGES-flop synchronizer (default 2). Comparator answers for codes presented before a restart are discarded, so they never trigger a capture.
- R7: `result_valid_o` is high for exactly one clock, in the cycle where the new result appears. In that same cycle `dac_code_o` is 0.
- R8: A synchronous reset (`rst_i` high at a clock edge) sets `dac_code_o`, `result_o` and `result_valid_o` to 0.
- R9: The code width is the parameter CODE_W, default 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmp_above_i | input | 1 | Comparator: 1 when the DAC output exceeds the analog input (asynchronous) |
| dac_code_o | output | CODE_W | Ramp code driven to the external DAC |
| result_o | output | CODE_W | Last captured conversion result |
| result_valid_o | output | 1 | One-clock strobe when `result_o` is loaded |

## Verification
Input levels 0 to 20 are swept one by one, so the short ramps expose any off-by-one in the result and any stale comparator answer left over from the previous ramp. Levels spread across mid-scale, together with 253 to 256 and levels far above full scale, separate a normal trip from the full-scale hold. Each level is also checked for its level-dependent spacing between valid pulses. A reset applied in the middle of a ramp confirms that all outputs clear together.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  // Next ramp code: counts up by one, parks on the top code.
  function automatic int unsigned ramp_next(input int unsigned code, input int unsigned top);
    return (code >= top) ? top : code + 1;
  endfunction

  // Clocks between two valid strobes for a given result.
  function automatic int unsigned conv_cycles(input int unsigned result, input int unsigned stages);
    return result + stages + 1;
  endfunction

endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[0] <= 1'b0;
          else       chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[i] <= 1'b0;
          else       chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              restart_i,
  output logic [CODE_W-1:0] code_o,
  output logic              at_top_o
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)          code_q <= '0;
    else if (restart_i) code_q <= '0;
    else                code_q <= CODE_W'(ramp_next(int'(code_q), int'(TOP)));
  end

  assign code_o   = code_q;
  assign at_top_o = (code_q == TOP);

  // R1: upward step of one while ramping
  a_r1_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (!restart_i && code_q != TOP) |=> (code_q == $past(code_q) + 1'b1));
  // R5: full-scale code parks until a capture
  a_r5_park: assert property (@(posedge clk_i) disable iff (rst_i)
    (!restart_i && code_q == TOP) |=> (code_q == TOP));
  // R7: restart returns the ramp to zero
  a_r7_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> (code_q == '0));
endmodule

// File: rtl/ramp_track.sv
module ramp_track #(
  parameter int CODE_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_old_o,
  output logic              fresh_o
);
  // Delays each presented code by the synchronizer depth so that it lines up
  // with its comparator answer; the fresh bit marks codes from the current ramp.
  logic [CODE_W-1:0] code_q  [STAGES];
  logic              fresh_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_tap
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) begin
            code_q[0]  <= '0;
            fresh_q[0] <= 1'b0;
          end else begin
            code_q[0]  <= code_i;
            fresh_q[0] <= !restart_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) begin
            code_q[i]  <= '0;
            fresh_q[i] <= 1'b0;
          end else begin
            code_q[i]  <= code_q[i-1];
            fresh_q[i] <= fresh_q[i-1] && !restart_i;
          end
        end
      end
    end
  endgenerate

  assign code_old_o = code_q[STAGES-1];
  assign fresh_o    = fresh_q[STAGES-1];

  // R6: nothing from before a restart survives into the next ramp
  a_r6_flush: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> !fresh_o);
endmodule

// File: rtl/ramp_capture.sv
module ramp_capture #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] value_i,
  output logic [CODE_W-1:0] result_o,
  output logic              valid_o
);
  logic [CODE_W-1:0] result_q;
  logic              valid_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) result_q <= value_i;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;

  // R3: result is held unless a load happens
  a_r3_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> $stable(result_q));
  // R7: strobe is a single clock
  a_r7_single: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_q |=> !valid_q);
  // R8: reset clears the outputs
  a_r8_reset: assert property (@(posedge clk_i)
    rst_i |=> (result_q == '0 && !valid_q));
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cmp_above_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [CODE_W-1:0] result_o,
  output logic              result_valid_o
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  logic              cmp_sync;
  logic [CODE_W-1:0] code_now;
  logic [CODE_W-1:0] code_old;
  logic              code_fresh;
  logic              at_top;
  logic              trip_evt;
  logic              full_evt;
  logic              load_evt;

  ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (cmp_above_i),
    .sync_o  (cmp_sync)
  );

  ramp_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (load_evt),
    .code_o    (code_now),
    .at_top_o  (at_top)
  );

  ramp_track #(.CODE_W(CODE_W), .STAGES(SYNC_STAGES)) u_track (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .restart_i  (load_evt),
    .code_i     (code_now),
    .code_old_o (code_old),
    .fresh_o    (code_fresh)
  );

  // Comparator answer for a code of the current ramp, or full scale reached untripped.
  assign trip_evt = code_fresh && cmp_sync;
  assign full_evt = code_fresh && !cmp_sync && (code_old == TOP);
  assign load_evt = trip_evt || full_evt;

  ramp_capture #(.CODE_W(CODE_W)) u_cap (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (load_evt),
    .value_i  (code_old),
    .result_o (result_o),
    .valid_o  (result_valid_o)
  );

  assign dac_code_o = code_now;

  // R5: a full-scale capture only happens while the counter is parked on top
  a_r5_full: assert property (@(posedge clk_i) disable iff (rst_i)
    full_evt |-> at_top);
  // R7: a valid strobe coincides with the ramp at zero
  a_r7_align: assert property (@(posedge clk_i) disable iff (rst_i)
    result_valid_o |-> (dac_code_o == '0));
  // R2: the captured code equals the delayed code on the load
  a_r2_capture: assert property (@(posedge clk_i) disable iff (rst_i)
    load_evt |=> (result_o == $past(code_old)));
endmodule

// File: tb/ramp_adc_ctrl_test.sv
`timescale 1ns/1ps
module ramp_adc_ctrl_test;
  localparam int W   = 8;
  localparam int TOP = (1 << W) - 1;
  localparam int LAT = 3;  // two synchronizer flops plus the decision register

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  int           level = 0;
  logic [W-1:0] code, result;
  logic         valid;
  logic         cmp;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // Behavioural DAC plus comparator: high once the code exceeds the level.
  assign cmp = (int'(code) > level);

  ramp_adc_ctrl #(.CODE_W(W), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_i(rst), .cmp_above_i(cmp),
    .dac_code_o(code), .result_o(result), .result_valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle monitor for R1, R3, R5, R7
  int  p_code = 0, p_res = 0;
  bit  p_valid = 0, p_rst = 1;
  always @(negedge clk) begin
    cycles++;
    if (!rst && !p_rst) begin
      if (valid) chk(code == 0, "R7 code zero on strobe", int'(code), 0);
      else if (p_code == TOP) chk(int'(code) == TOP, "R5 park at top", int'(code), TOP);
      else chk(int'(code) == p_code + 1, "R1 step", int'(code), p_code + 1);
      if (!valid) chk(int'(result) == p_res, "R3 hold", int'(result), p_res);
      if (p_valid) chk(!valid, "R7 single pulse", int'(valid), 0);
    end
    p_code = int'(code); p_res = int'(result); p_valid = valid; p_rst = rst;
  end

  task automatic wait_valid(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!valid && n < 2000);
    if (!valid) begin
      chk(0, "watchdog", n, 0);
      done = 1;
    end
  endtask

  task automatic measure(input int lv);
    int n;
    int exp_r;
    level = lv;
    wait_valid(n);  // ramp in progress when the level changed
    if (done) return;
    wait_valid(n);
    if (done) return;
    exp_r = (lv + 1 > TOP) ? TOP : lv + 1;
    chk(int'(result) == exp_r, "R2/R6 result", int'(result), exp_r);
    wait_valid(n);
    if (done) return;
    chk(n == exp_r + LAT, "R4 spacing", n, exp_r + LAT);
    if (lv >= TOP) chk(int'(result) == TOP, "R5 full scale", int'(result), TOP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 / R9: reset state on an 8-bit default width
    chk(code == 0 && result == 0 && !valid, "R8 reset state", int'(code), 0);
    chk($bits(code) == 8, "R9 width", $bits(code), 8);
    rst = 1'b0;
    for (int v = 0; v <= 20 && !done; v++) measure(v);
    for (int v = 27; v < 250 && !done; v += 37) measure(v);
    for (int v = 253; v <= 256 && !done; v++) measure(v);
    if (!done) measure(400);
    if (!done) begin
      level = 200;
      repeat (50) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(code == 0 && result == 0 && !valid, "R8 mid-ramp reset",
          int'(code) + int'(result), 0);
      rst = 1'b0;
      measure(5);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule